// File: doc/BRIEF.md
# Clock Output Enable Sequencer

This block passes a clock made elsewhere on the chip to two identical outputs. An active-low enable controls the gate. The enable may change at any time relative to either clock. When the enable goes low, the block counts a fixed number of reference-clock cycles before the first output rising edge is allowed out. This gives the clock source time to settle before its clock is used downstream. The rate select sets that count: a slow reference waits 200 cycles and a fast reference waits 400 cycles.

When the enable goes high again, the output high phase in progress runs to its normal end. Both outputs then stay low. The gate only ever changes while the generated clock is low, so no output pulse is ever cut short, whether the gate is opening or closing. A ready flag reports that the gate is open.

The delay counter advances only on reference edges. If the reference is not toggling, the outputs stay closed indefinitely. Releasing the enable during the count clears the count, so the next assertion starts again from zero.

Top module: `clkout_enable_seq`

## Requirements
- R1: While reset is asserted, `clk_a`, `clk_b` and `ready` are low.
- R2: While `en_n` is high and a few generated-clock cycles have passed since it rose, `clk_a`, `clk_b` and `ready` stay low.
- R3: With `rate_sel` = 0 (slow reference), after `en_n` falls, the first rising edge of `clk_a` comes after the 202nd reference rising edge and before the 203rd. That is 2 edges of synchronization and 200 counted edges. From then on, `clk_a` carries every generated-clock pulse.
- R4: With `rate_sel` = 1 (fast reference), the first rising edge of `clk_a` comes after the 402nd reference rising edge following the fall of `en_n`, and before the 403rd.
- R5: When `en_n` rises during an output high phase, that high phase completes. Within six generated-clock cycles the outputs and `ready` go low and stay low.
- R6: Every high phase on `clk_a` lasts exactly one full generated-clock high phase, including the first pulse after enabling and the last pulse before disabling.
- R7: `clk_b` equals `clk_a` at all times.
- R8: If `en_n` goes high at any point during the delay count, the count is cleared. The next assertion waits the full count again.
- R9: With no reference edges, the count does not advance and the outputs stay low. Once the reference starts, the full count, including synchronization, is waited from its first edge.
- R10: `ready` stays low through the delay count and is high while the outputs are passing the generated clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that paces the enable delay |
| gen_clk | input | 1 | Generated clock that is gated onto the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | Reference rate select: 0 = slow (200 cycles), 1 = fast (400 cycles) |
| en_n | input | 1 | Asynchronous active-low output enable |
| clk_a | output | 1 | First gated clock output |
| clk_b | output | 1 | Second gated clock output, identical to clk_a |
| ready | output | 1 | High while the gate is open |

## Verification
Two events can fall in the same generated-clock cycle. One is the end of the delay count, which opens the gate. The other is the arrival of a disable, which closes it. The bench provokes this by releasing `en_n` three nanoseconds before the reference edge on which the count completes, with the fast rate selected. It judges the outcome from the ports. Any pulses that escape must have full width. After that, the outputs and `ready` must settle low and stay low.

// File: rtl/ogs_pkg.sv
package ogs_pkg;

    // Reference-rate encoding on the rate_sel pin
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    parameter int unsigned DEF_SLOW_CYCLES = 200;
    parameter int unsigned DEF_FAST_CYCLES = 400;
    parameter int unsigned DEF_SYNC_STAGES = 2;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ogs_sync.sv
module ogs_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef logic [WIDTH-1:0] word_t;

    word_t chain_d [STAGES];
    word_t chain_q [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ogs_ref_count.sv
module ogs_ref_count #(
    parameter int unsigned SLOW_CYCLES = ogs_pkg::DEF_SLOW_CYCLES,
    parameter int unsigned FAST_CYCLES = ogs_pkg::DEF_FAST_CYCLES,
    parameter int unsigned SYNC_STAGES = ogs_pkg::DEF_SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic en_async,
    input  logic rate_async,
    output logic count_done
);
    localparam int unsigned MAX_CYCLES = ogs_pkg::max_u(SLOW_CYCLES, FAST_CYCLES);
    localparam int unsigned CW         = $clog2(MAX_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t           s_d, s_q;
    logic          en_s;
    logic          rate_s;
    logic [CW-1:0] last_d;

    ogs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ref_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     ({rate_async, en_async}),
        .q     ({rate_s, en_s})
    );

    always_comb begin
        last_d = (rate_s == ogs_pkg::RATE_FAST) ? CW'(FAST_CYCLES - 1) : CW'(SLOW_CYCLES - 1);
        s_d    = s_q;
        if (!en_s) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (!s_q.done) begin
            if (s_q.cnt >= last_d) begin
                s_d.cnt  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_done = s_q.done;

    AST_COUNT_BELOW_LIMIT: assert property (@(posedge ref_clk) disable iff (!rst_n)
        32'(s_q.cnt) < MAX_CYCLES); // R4

    AST_ABORT_CLEARS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !en_s |=> (s_q.cnt == '0) && !s_q.done); // R8

    AST_DONE_HELD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (s_q.done && en_s) |=> s_q.done); // R3

endmodule

// File: rtl/ogs_gate.sv
module ogs_gate #(
    parameter int unsigned SYNC_STAGES = ogs_pkg::DEF_SYNC_STAGES
) (
    input  logic gen_clk,
    input  logic rst_n,
    input  logic en_async,
    input  logic done_async,
    output logic gate_open
);
    typedef struct packed {
        logic open;
    } st_t;

    st_t  g_d, g_q;
    logic en_g;
    logic done_g;

    ogs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_gen_sync (
        .clk   (gen_clk),
        .rst_n (rst_n),
        .d     ({done_async, en_async}),
        .q     ({done_g, en_g})
    );

    always_comb begin
        g_d      = g_q;
        g_d.open = en_g && done_g;
    end

    // The gate register updates on the falling edge so it changes only while gen_clk is low.
    always_ff @(negedge gen_clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gate_open = g_q.open;

    AST_CLOSE_ON_DISABLE: assert property (@(posedge gen_clk) disable iff (!rst_n)
        !en_g |=> !g_q.open); // R5

    AST_OPEN_NEEDS_DONE: assert property (@(posedge gen_clk) disable iff (!rst_n)
        $rose(g_q.open) |-> (done_g && en_g)); // R3

endmodule

// File: rtl/clkout_enable_seq.sv
module clkout_enable_seq #(
    parameter int unsigned SLOW_CYCLES = ogs_pkg::DEF_SLOW_CYCLES,
    parameter int unsigned FAST_CYCLES = ogs_pkg::DEF_FAST_CYCLES,
    parameter int unsigned SYNC_STAGES = ogs_pkg::DEF_SYNC_STAGES
) (
    input  logic ref_clk,
    input  logic gen_clk,
    input  logic rst_n,
    input  logic rate_sel,
    input  logic en_n,
    output logic clk_a,
    output logic clk_b,
    output logic ready
);
    logic en_act;
    logic count_done;
    logic gate_open;

    assign en_act = ~en_n;

    ogs_ref_count #(
        .SLOW_CYCLES (SLOW_CYCLES),
        .FAST_CYCLES (FAST_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_count (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .en_async   (en_act),
        .rate_async (rate_sel),
        .count_done (count_done)
    );

    ogs_gate #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_gate (
        .gen_clk    (gen_clk),
        .rst_n      (rst_n),
        .en_async   (en_act),
        .done_async (count_done),
        .gate_open  (gate_open)
    );

    assign clk_a = gen_clk & gate_open;
    assign clk_b = gen_clk & gate_open;
    assign ready = gate_open;

    AST_READY_LOW_IN_RESET: assert property (@(posedge gen_clk)
        !rst_n |-> !ready); // R1

endmodule

// File: tb/tb_clkout_enable_seq.sv
`timescale 1ns/1ps
module tb_clkout_enable_seq;
    localparam int SLOW = 200;
    localparam int FAST = 400;

    logic ref_clk = 1'b0, gen_clk = 1'b0, rst_n = 1'b0;
    logic rate_sel = 1'b0, en_n = 1'b1;
    logic clk_a, clk_b, ready;
    bit   ref_run = 1'b1;
    bit   rise_flag = 1'b0;
    int   rise_cnt = 0;
    int   vecs = 0, fails = 0;
    time  t_rise = 0;

    clkout_enable_seq dut (
        .ref_clk(ref_clk), .gen_clk(gen_clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .en_n(en_n), .clk_a(clk_a), .clk_b(clk_b), .ready(ready)
    );

    always #4 gen_clk = ~gen_clk;

    initial begin
        #1;
        forever begin
            #40;
            if (ref_run) ref_clk = ~ref_clk;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk_a) begin
        rise_flag = 1'b1;
        rise_cnt++;
        t_rise = $time;
    end

    always @(negedge clk_a) begin
        check(($time - t_rise) == 4, "R6", "high phase width ns", int'($time - t_rise), 4);
    end

    always @(gen_clk) begin
        #1;
        if (clk_a !== clk_b) check(1'b0, "R7", "clk_b vs clk_a", int'(clk_b), int'(clk_a));
    end

    task automatic count_to_rise(output int n, output bit early);
        n = 0;
        early = 1'b0;
        while (n < 1000) begin
            @(posedge ref_clk);
            #1;
            if (rise_flag) break;
            if (ready) early = 1'b1;
            n++;
        end
    endtask

    task automatic t_reset();
        #20;
        check(clk_a == 0 && clk_b == 0, "R1", "outputs in reset", int'(clk_a | clk_b), 0);
        check(ready == 0, "R1", "ready in reset", int'(ready), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_enable(input bit rate, input string req, input int lim);
        int n; bit early; int r0;
        en_n = 1'b1;
        rate_sel = rate;
        repeat (6) @(posedge ref_clk);
        #1;
        check(clk_a == 0 && ready == 0, "R2", "idle while disabled", int'(clk_a | ready), 0);
        @(negedge ref_clk); #2;
        rise_flag = 1'b0;
        en_n = 1'b0;
        count_to_rise(n, early);
        check(n == lim + 2, req, "ref edges before first rise", n, lim + 2);
        check(!early, "R10", "ready during count", int'(early), 0);
        @(negedge gen_clk); #1;
        check(ready == 1, "R10", "ready after open", int'(ready), 1);
        r0 = rise_cnt;
        repeat (20) @(negedge gen_clk);
        check(rise_cnt - r0 == 20, req, "pulses in 20 cycles", rise_cnt - r0, 20);
    endtask

    task automatic t_disable();
        int r1; bit bad;
        @(posedge clk_a); #1;
        en_n = 1'b1;
        #1;
        check(clk_a == 1, "R5", "high phase continues", int'(clk_a), 1);
        repeat (6) @(negedge gen_clk);
        r1 = rise_cnt;
        bad = 1'b0;
        repeat (30) begin
            @(posedge gen_clk); #1;
            if (clk_a | clk_b | ready) bad = 1'b1;
        end
        check(!bad, "R5", "outputs low after disable", int'(bad), 0);
        check(rise_cnt == r1, "R5", "no new pulses", rise_cnt - r1, 0);
    endtask

    task automatic t_abort();
        int n; bit early;
        en_n = 1'b1;
        rate_sel = 1'b0;
        repeat (6) @(posedge ref_clk);
        @(negedge ref_clk); #2;
        rise_flag = 1'b0;
        en_n = 1'b0;
        repeat (150) @(posedge ref_clk);
        @(negedge ref_clk); #2;
        en_n = 1'b1;
        repeat (6) @(posedge ref_clk);
        #1;
        check(!rise_flag && ready == 0, "R8", "no output after abort", int'(rise_flag), 0);
        @(negedge ref_clk); #2;
        en_n = 1'b0;
        count_to_rise(n, early);
        check(n == SLOW + 2, "R8", "full recount after abort", n, SLOW + 2);
        en_n = 1'b1;
        repeat (4) @(posedge ref_clk);
    endtask

    task automatic t_noref();
        int n; bit early; bit bad;
        en_n = 1'b1;
        rate_sel = 1'b0;
        repeat (6) @(posedge ref_clk);
        @(negedge ref_clk); #2;
        ref_run = 1'b0;
        rise_flag = 1'b0;
        #100;
        en_n = 1'b0;
        bad = 1'b0;
        repeat (3000) begin
            @(posedge gen_clk); #1;
            if (clk_a | ready) bad = 1'b1;
        end
        check(!bad && !rise_flag, "R9", "outputs low without reference", int'(bad), 0);
        ref_run = 1'b1;
        count_to_rise(n, early);
        check(n == SLOW + 2, "R9", "full count after reference starts", n, SLOW + 2);
        en_n = 1'b1;
        repeat (4) @(posedge ref_clk);
    endtask

    task automatic t_race();
        bit bad;
        en_n = 1'b1;
        rate_sel = 1'b1;
        repeat (6) @(posedge ref_clk);
        @(negedge ref_clk); #2;
        en_n = 1'b0;
        repeat (FAST + 1) @(posedge ref_clk);
        @(negedge ref_clk); #37;
        en_n = 1'b1;
        repeat (5) @(posedge ref_clk);
        bad = 1'b0;
        repeat (40) begin
            @(posedge gen_clk); #1;
            if (clk_a | clk_b | ready) bad = 1'b1;
        end
        check(!bad, "R5", "settled low after disable racing count end", int'(bad), 0);
    endtask

    initial begin
        #1_200_000;
        check(1'b0, "watchdog", "run time expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_enable(1'b0, "R3", SLOW);
        t_disable();
        t_enable(1'b1, "R4", FAST);
        t_disable();
        t_abort();
        t_noref();
        t_race();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule